// File: doc/BRIEF.md
# Three-Channel Edge Timestamp Timer

The block keeps a 16-bit free-running count whose rate is set by a programmable power-of-two prescaler. Three external input pins are watched independently. When a pin shows the edge its channel is configured for, the running count is copied into that channel's capture register, and the channel's event flag is raised. Software compares two captured stamps to measure periods, pulse widths or the arrival order of signals. A wrap flag marks the count rolling over, so that software can correct a difference taken across a rollover.

Software reaches the block through a byte-wide register port with a single address bus. Reads return their data one cycle after the request. Each channel has an interrupt enable. The block raises one interrupt line, gated by a global mask input, and reports which channel it is serving. The lowest-numbered pending channel has priority.

Register map (4-bit address):
- 0x0 and 0x1 hold the running count, high byte and low byte.
- 0x2 to 0x7 hold the capture registers, high byte then low byte, for channels 1, 2 and 3 in turn.
- 0x8 is the control register.
- 0x9 holds the flags.
- 0xA holds the interrupt enables.

Top module: `edge_stamp_timer`

## Requirements
- R1: Control register 0x8 holds a 2-bit edge code for each channel: bits [1:0] for channel 1, [3:2] for channel 2 and [5:4] for channel 3. Code 00 never captures, 01 captures on a rising edge, 10 on a falling edge and 11 on either edge.
- R2: A qualifying edge loads the running count into that channel's capture register and overwrites any earlier stamp. With prescale 1, two captures taken d clock cycles apart differ by d, modulo 2^16.
- R3: Writes to the capture register addresses 0x2 to 0x7 leave the captured values unchanged.
- R4: Flag register 0x9 bits 0, 1 and 2 are the flags of channels 1, 2 and 3. A capture sets its flag. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and every flag is 0 after reset.
- R5: When a capture and a write of 1 to the same flag fall in the same cycle, the flag ends up set.
- R6: Enable register 0xA bits 0 to 2 are per-channel interrupt enables and reset to 0. irq_o is high exactly when some channel has both its flag and its enable set and irq_gate_i is 1.
- R7: irq_id_o gives the number (1 to 3) of the lowest-numbered channel that is both flagged and enabled while irq_o is high. It is 0 when irq_o is low.
- R8: The count wraps from 0xFFFF to 0x0000 and sets flag register bit 7. That bit is cleared by writing 1 to it.
- R9: Control register bits [7:6] hold a prescale select s that resets to 0. The count advances once every 2^s clock cycles.
- R10: Each pin passes through two synchronising flops. A pin change driven between two clock edges updates the flag and the capture register at the third rising clock edge after it.
- R11: Reading a channel's high byte stores that channel's low byte. The next read of that channel's low byte returns the stored byte, even if a newer capture has occurred. A low-byte read with no stored byte returns the live low byte.
- R12: rdata_o is loaded with the addressed register on each clock edge where rd_en_i is high, and holds its value otherwise. Reads of 0x0 and 0x1 return the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | 3 | Capture pins; bit 0 is channel 1 |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_gate_i | input | 1 | Global interrupt mask; 1 allows the interrupt |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 2 | Channel being served, 0 when none |

## Verification
Two situations are hard to reach from the ports. The first is a capture landing in the very cycle that software writes 1 to the same flag. The bench reaches it by counting the three-edge pin latency: it changes the pin on a falling clock edge and raises the flag-clear write two falling edges later, so both act on the same rising edge. The second is a rollover of the count between two stamps. The bench spaces two captures 70000 cycles apart at prescale 1, then checks both the wrapped difference and the wrap flag.

// File: rtl/est_pkg.sv
package est_pkg;
  localparam int NUM_CH  = 3;
  localparam int CNT_W   = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int SEL_W   = 2;
  localparam int ID_W    = $clog2(NUM_CH + 1);

  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h1;
  localparam int                A_CAP_BASE = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'h9;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'hA;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  function automatic logic [ADDR_W-1:0] cap_hi_addr(input int k);
    return ADDR_W'(A_CAP_BASE + 2 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] cap_lo_addr(input int k);
    return ADDR_W'(A_CAP_BASE + 2 * k + 1);
  endfunction
endpackage

// File: rtl/est_pin_sync.sv
module est_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/est_cap_chan.sv
module est_cap_chan
  import est_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  edge_mode_e       mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  logic             hit;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  always_comb begin
    unique case (mode_i)
      EDGE_OFF:  hit = 1'b0;
      EDGE_RISE: hit = rise_i;
      EDGE_FALL: hit = fall_i;
      EDGE_ANY:  hit = rise_i | fall_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (hit) cap_q <= count_i;
      // a new event outranks a clear in the same cycle
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  // R2
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(cap_q));
  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);
  // R4
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit));
endmodule

// File: rtl/est_free_counter.sv
module est_free_counter
  import est_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0]    presc_q, mask;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;

  assign mask = ~({PW{1'b1}} << sel_i);
  assign tick = (presc_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = tick && (cnt_q == '1);

  // R9
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));
  // R8
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
  import est_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] cap_pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              irq_gate_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);
  logic [NUM_CH-1:0]   rise, fall, flag, clr, req;
  logic [CNT_W-1:0]    cap_val [NUM_CH];
  edge_mode_e          mode    [NUM_CH];
  logic [CNT_W-1:0]    count;
  logic                cnt_wrap;
  logic [2*NUM_CH-1:0] edge_cfg_q;
  logic [SEL_W-1:0]    sel_q;
  logic [NUM_CH-1:0]   ien_q;
  logic                ovf_q;
  logic [DATA_W-1:0]   lo_hold_q [NUM_CH];
  logic [NUM_CH-1:0]   held_q;
  logic [DATA_W-1:0]   rd_mux, rdata_q;
  logic [ID_W-1:0]     id_sel;
  logic                flag_wr;

  assign flag_wr = wr_en_i && (addr_i == A_FLAG);

  est_free_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_q),
    .count_o(count),
    .wrap_o (cnt_wrap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign mode[g] = edge_mode_e'(edge_cfg_q[2*g +: 2]);
    assign clr[g]  = flag_wr && wdata_i[g];

    est_pin_sync u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (cap_pin_i[g]),
      .rise_o(rise[g]),
      .fall_o(fall[g])
    );

    est_cap_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode[g]),
      .rise_i (rise[g]),
      .fall_i (fall[g]),
      .count_i(count),
      .clr_i  (clr[g]),
      .cap_o  (cap_val[g]),
      .flag_o (flag[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cfg_q <= '0;
      sel_q      <= '0;
      ien_q      <= '0;
      ovf_q      <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_CTRL) {sel_q, edge_cfg_q} <= wdata_i;
      if (wr_en_i && addr_i == A_IEN)  ien_q <= wdata_i[NUM_CH-1:0];
      if (cnt_wrap)                        ovf_q <= 1'b1;
      else if (flag_wr && wdata_i[DATA_W-1]) ovf_q <= 1'b0;
    end
  end

  // high-byte read freezes the low byte for a coherent 16-bit pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      for (int k = 0; k < NUM_CH; k++) lo_hold_q[k] <= '0;
    end else if (rd_en_i) begin
      for (int k = 0; k < NUM_CH; k++) begin
        if (addr_i == cap_hi_addr(k)) begin
          lo_hold_q[k] <= cap_val[k][DATA_W-1:0];
          held_q[k]    <= 1'b1;
        end else if (addr_i == cap_lo_addr(k)) begin
          held_q[k]    <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CNT_HI: rd_mux = count[CNT_W-1:DATA_W];
      A_CNT_LO: rd_mux = count[DATA_W-1:0];
      A_CTRL:   rd_mux = {sel_q, edge_cfg_q};
      A_FLAG:   rd_mux = {ovf_q, {(DATA_W-1-NUM_CH){1'b0}}, flag};
      A_IEN:    rd_mux = {{(DATA_W-NUM_CH){1'b0}}, ien_q};
      default:  rd_mux = '0;
    endcase
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == cap_hi_addr(k)) rd_mux = cap_val[k][CNT_W-1:DATA_W];
      if (addr_i == cap_lo_addr(k))
        rd_mux = held_q[k] ? lo_hold_q[k] : cap_val[k][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  // lowest channel number wins
  always_comb begin
    req    = flag & ien_q;
    id_sel = '0;
    for (int k = NUM_CH - 1; k >= 0; k--)
      if (req[k]) id_sel = ID_W'(k + 1);
  end

  assign irq_o    = (|req) && irq_gate_i;
  assign irq_id_o = irq_o ? id_sel : '0;

  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(cnt_wrap));
  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_gate_i);
  // R7
  irq_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_id_o != '0));
  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/edge_stamp_timer_bench.sv
`timescale 1ns/1ps
module edge_stamp_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin = 3'b000;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gate = 1'b0;
  logic       irq;
  logic [1:0] irq_id;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_stamp_timer u_edge_stamp_timer (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .addr_i(addr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .irq_gate_i(gate), .irq_o(irq), .irq_id_o(irq_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd(4'(2 + 2*ch), h);
    rd(4'(3 + 2*ch), l);
    v = {h, l};
  endtask

  task automatic set_pin(input int k, input logic v, output int t);
    @(negedge clk); pin[k] = v; t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'h8, d); chk("R1 ctrl reset", d, 0);
    rd(4'h9, d); chk("R4 flags reset", d, 0);
    rd(4'hA, d); chk("R6 enables reset", d, 0);
    chk("R6 irq reset", irq, 0);
    chk("R7 id reset", irq_id, 0);
  endtask

  task automatic t_latency;
    wr(4'h8, 8'h01);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 4'h9; rd_en = 1'b1;
    @(negedge clk); chk("R10 flag before third edge", rdata[0], 0);
    @(negedge clk); chk("R10 flag at third edge", rdata[0], 1);
    rd_en = 1'b0;
    pin[0] = 1'b0;
    idle(5);
  endtask

  task automatic t_edges;
    logic [7:0] d;
    wr(4'h8, 8'h09); wr(4'h9, 8'h87);
    @(negedge clk); pin = 3'b111; idle(5);
    rd(4'h9, d); chk("R1 rising only ch1", d & 8'h07, 1);
    wr(4'h9, 8'h07);
    @(negedge clk); pin = 3'b000; idle(5);
    rd(4'h9, d); chk("R1 falling only ch2", d & 8'h07, 2);
    wr(4'h8, 8'h39); wr(4'h9, 8'h07);
    @(negedge clk); pin[2] = 1'b1; idle(5);
    rd(4'h9, d); chk("R1 any edge rise", d & 8'h07, 4);
    wr(4'h9, 8'h07);
    @(negedge clk); pin[2] = 1'b0; idle(5);
    rd(4'h9, d); chk("R1 any edge fall", d & 8'h07, 4);
  endtask

  task automatic t_stamps;
    int t1, t2, t3, tx;
    logic [15:0] v1, v2, v3;
    logic [7:0] c0, c1;
    wr(4'h8, 8'h05);
    set_pin(0, 1'b1, t1); idle(9);
    set_pin(1, 1'b1, t2); idle(5);
    rd16(0, v1); rd16(1, v2);
    chk("R2 stamp difference", 16'(v2 - v1), 16'(t2 - t1));
    set_pin(0, 1'b0, tx); idle(20);
    set_pin(0, 1'b1, t3); idle(5);
    rd16(0, v3);
    chk("R2 overwrite", 16'(v3 - v1), 16'(t3 - t1));
    rd(4'h1, c0); rd(4'h1, c1);
    chk("R12 live count", 8'(c1 - c0), 2);
    wr(4'h2, 8'hA5); wr(4'h3, 8'h5A);
    rd16(0, v2);
    chk("R3 capture write ignored", v2, v3);
  endtask

  task automatic t_hold;
    int t1, t2;
    logic [15:0] v1, v2;
    logic [7:0] d;
    wr(4'h8, 8'h07);
    set_pin(0, 1'b0, t1); idle(5);
    rd16(0, v1);
    rd(4'h2, d);
    set_pin(0, 1'b1, t2); idle(5);
    rd(4'h3, d);
    chk("R11 held low byte", d, v1[7:0]);
    rd(4'h3, d);
    chk("R11 live low byte", d, 8'(v1 + 16'(t2 - t1)));
    rd16(0, v2);
    chk("R11 new stamp", 16'(v2 - v1), 16'(t2 - t1));
  endtask

  task automatic t_irq;
    int tx;
    logic [7:0] d;
    wr(4'h8, 8'h15);
    @(negedge clk); pin = 3'b000; idle(5);
    wr(4'h9, 8'h87); wr(4'hA, 8'h06);
    gate = 1'b1;
    @(negedge clk); pin = 3'b110; idle(5);
    chk("R6 irq raised", irq, 1);
    chk("R7 id ch2 over ch3", irq_id, 2);
    gate = 1'b0; @(negedge clk);
    chk("R6 irq gated", irq, 0);
    chk("R7 id gated", irq_id, 0);
    gate = 1'b1;
    wr(4'h9, 8'h02); @(negedge clk);
    chk("R7 id ch3", irq_id, 3);
    set_pin(0, 1'b1, tx); idle(5);
    chk("R7 disabled ch1 ignored", irq_id, 3);
    wr(4'hA, 8'h07); @(negedge clk);
    chk("R7 id ch1 wins", irq_id, 1);
    rd(4'h9, d); chk("R4 flags set", d & 8'h07, 5);
    wr(4'h9, 8'h00);
    rd(4'h9, d); chk("R4 write zero keeps", d & 8'h07, 5);
    wr(4'h9, 8'h01);
    rd(4'h9, d); chk("R4 write one clears", d & 8'h07, 4);
    wr(4'hA, 8'h00); @(negedge clk);
    chk("R6 irq off when disabled", irq, 0);
  endtask

  task automatic t_set_wins;
    int tx;
    logic [7:0] d;
    set_pin(1, 1'b0, tx); idle(5);
    wr(4'h9, 8'h07);
    rd(4'h9, d); chk("R5 precondition", d & 8'h02, 0);
    @(negedge clk); pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 4'h9; wdata = 8'h02; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(4'h9, d); chk("R5 set beats clear", d & 8'h02, 2);
  endtask

  task automatic t_prescale;
    int t1, t2;
    logic [15:0] v1, v2;
    wr(4'h8, 8'h85);
    @(negedge clk); pin = 3'b000; idle(5);
    set_pin(0, 1'b1, t1); idle(63);
    set_pin(1, 1'b1, t2); idle(10);
    rd16(0, v1); rd16(1, v2);
    chk("R9 divide by four", 16'(v2 - v1), (t2 - t1) / 4);
    wr(4'h8, 8'h05);
    @(negedge clk); pin = 3'b000; idle(5);
  endtask

  task automatic t_wrap;
    int t1, t2;
    logic [15:0] v1, v2;
    logic [7:0] d;
    wr(4'h9, 8'h80);
    rd(4'h9, d); chk("R8 wrap flag clear", d[7], 0);
    set_pin(0, 1'b1, t1); idle(69999);
    set_pin(1, 1'b1, t2); idle(5);
    rd16(0, v1); rd16(1, v2);
    chk("R8 difference across wrap", 16'(v2 - v1), 16'(t2 - t1));
    rd(4'h9, d); chk("R8 wrap flag set", d[7], 1);
    wr(4'h9, 8'h80);
    rd(4'h9, d); chk("R8 wrap flag cleared", d[7], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_latency;
    t_edges;
    t_stamps;
    t_hold;
    t_irq;
    t_set_wins;
    t_prescale;
    t_wrap;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule